// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits (16 by default) and returns the full `2*WIDTH`-bit signed product. The multiplier operand is recoded into radix-4 digits drawn from {-2, -1, 0, +1, +2}. A zero bit is placed below its least significant bit, and overlapping three-bit windows are read from it. Each digit selects one partial-product row built from the multiplicand, so the block makes `WIDTH/2` rows instead of `WIDTH`.

Rows for negative digits are inverted bitwise. The missing +1 of each such row is added back as a separate correction bit in the row's lowest column. No row is sign-extended across the product width. Instead, each row's sign bit is inverted and a few constant bits are placed beside it. A chain of carry-save adders reduces the rows, the correction vector and the template bits to a sum and a carry vector. One carry-propagate adder then combines these two vectors.

The product goes to a register and appears one clock cycle after the operands are presented with `valid_i` high. When `valid_i` is low, the registered product keeps its last value.

Top module: `booth_mul`

## Requirements
- R1: When `valid_i` is high at a rising clock edge, `product_o` after that edge equals the signed product of `a_i` and `b_i` as a `2*WIDTH`-bit two's-complement value.
- R2: `valid_o` equals the value `valid_i` had at the previous rising clock edge.
- R3: When `valid_i` is low at a rising clock edge, `product_o` keeps its value, whatever `a_i` and `b_i` hold.
- R4: While `rst_ni` is low, `valid_o` is 0 and `product_o` is all zeros.
- R5: Each three-bit multiplier window {b[2j+1], b[2j], b[2j-1]}, with b[-1] = 0, maps to a digit as follows: 000→0, 001→+1, 010→+1, 011→+2, 100→-2, 101→-1, 110→-1, 111→0. Multiplier values that produce every window, including the all-ones window (negative zero), give correct products.
- R6: The most negative operand (0x8000 at 16 bits) is handled without overflow. 0x8000 × 0x8000 gives 0x40000000, and 0x8000 × 0xFFFF gives 0x00008000, in either operand order.
- R7: 25 × -35 gives -875 (0xFFFFFC95).
- R8: If either operand is zero, the product is zero.
- R9: If both operands are nonzero, bit `2*WIDTH-1` of the product equals the exclusive-or of the two operand sign bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands on `a_i`/`b_i` are to be multiplied |
| a_i | input | WIDTH | Multiplicand, signed two's complement |
| b_i | input | WIDTH | Multiplier, signed two's complement, Booth-recoded |
| valid_o | output | 1 | `product_o` was loaded at the last edge |
| product_o | output | 2*WIDTH | Signed product, registered |

## Verification
The bench targets the most negative multiplicand, whose ±2 multiple needs the extra row bit. A row generator one bit too narrow would return a product wrong in its upper half for 0x8000 × 0x8000. Multipliers of all ones and of alternating bit pairs use the negative-zero window and every nonzero digit. A missing correction bit or a wrong group mapping would show up as small offsets or wrong multiples in these products. Operand pairs with mixed signs and with zero test the constant sign template, which would leave a wrong high half or a nonzero product for zero inputs if a template bit were misplaced. Idle cycles with changing operands show whether the output register loads only on valid input.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef struct packed {
    logic neg;  // digit is negative
    logic two;  // magnitude 2
    logic one;  // magnitude 1
  } booth_digit_t;

  // window {b[2j+1], b[2j], b[2j-1]} -> signed digit
  function automatic booth_digit_t recode(input logic [2:0] win);
    booth_digit_t d;
    d.neg = win[2];
    d.one = win[1] ^ win[0];
    d.two = (win[2] & ~win[1] & ~win[0]) | (~win[2] & win[1] & win[0]);
    return d;
  endfunction

endpackage

// File: rtl/booth_digit_enc.sv
module booth_digit_enc
  import booth_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]                    b_i,
  output booth_digit_t [WIDTH/2-1:0]          digits_o
);
  localparam int ROWS = WIDTH / 2;

  logic [WIDTH:0] b_ext;
  assign b_ext = {b_i, 1'b0};

  for (genvar j = 0; j < ROWS; j++) begin : g_dig
    assign digits_o[j] = recode(b_ext[2*j +: 3]);
  end

endmodule

// File: rtl/booth_row_gen.sv
module booth_row_gen
  import booth_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  booth_digit_t     digit_i,
  output logic [WIDTH:0]   row_o
);
  logic [WIDTH:0] mag;

  always_comb begin
    if (digit_i.one)      mag = {a_i[WIDTH-1], a_i};
    else if (digit_i.two) mag = {a_i, 1'b0};
    else                  mag = '0;
  end

  // ones' complement for negative digits; +1 added elsewhere
  assign row_o = mag ^ {(WIDTH+1){digit_i.neg}};

endmodule

// File: rtl/csa_chain.sv
module csa_chain #(
  parameter int PW   = 32,
  parameter int NUMR = 9
) (
  input  logic [PW-1:0] rows_i [NUMR],
  output logic [PW-1:0] sum_o,
  output logic [PW-1:0] carry_o
);
  localparam int STAGES = NUMR - 2;

  logic [PW-1:0] s_q [STAGES+1];
  logic [PW-1:0] c_q [STAGES+1];

  assign s_q[0] = rows_i[0];
  assign c_q[0] = rows_i[1];

  for (genvar k = 0; k < STAGES; k++) begin : g_csa
    logic [PW-1:0] x;
    assign x          = rows_i[k+2];
    assign s_q[k+1]   = s_q[k] ^ c_q[k] ^ x;
    assign c_q[k+1]   = ((s_q[k] & c_q[k]) | (s_q[k] & x) | (c_q[k] & x)) << 1;
  end

  assign sum_o   = s_q[STAGES];
  assign carry_o = c_q[STAGES];

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [WIDTH-1:0]     a_i,
  input  logic [WIDTH-1:0]     b_i,
  output logic                 valid_o,
  output logic [2*WIDTH-1:0]   product_o
);
  localparam int ROWS = WIDTH / 2;
  localparam int PW   = 2 * WIDTH;
  localparam int NUMR = ROWS + 1;

  booth_digit_t [ROWS-1:0] digits;
  logic [WIDTH:0]          row   [ROWS];
  logic [PW-1:0]           pp    [NUMR];
  logic [PW-1:0]           corr;
  logic [PW-1:0]           red_sum, red_carry, result;
  logic                    valid_q;
  logic [PW-1:0]           prod_q;

  booth_digit_enc #(.WIDTH(WIDTH)) i_enc (
    .b_i      (b_i),
    .digits_o (digits)
  );

  for (genvar j = 0; j < ROWS; j++) begin : g_row
    logic sgn;

    booth_row_gen #(.WIDTH(WIDTH)) i_row (
      .a_i     (a_i),
      .digit_i (digits[j]),
      .row_o   (row[j])
    );

    assign sgn = row[j][WIDTH];

    // sign template: first row gets {~s, s, s}, later rows {1, ~s}
    if (j == 0) begin : g_first
      assign pp[j] = PW'({~sgn, sgn, sgn, row[j][WIDTH-1:0]});
    end else begin : g_rest
      assign pp[j] = PW'({1'b1, ~sgn, row[j][WIDTH-1:0]}) << (2*j);
    end
  end

  // +1 of each inverted row at its lowest column
  always_comb begin
    corr = '0;
    for (int j = 0; j < ROWS; j++) corr[2*j] = digits[j].neg;
  end
  assign pp[ROWS] = corr;

  csa_chain #(.PW(PW), .NUMR(NUMR)) i_csa (
    .rows_i  (pp),
    .sum_o   (red_sum),
    .carry_o (red_carry)
  );

  assign result = red_sum + red_carry;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      prod_q  <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) prod_q <= result;
    end
  end

  assign valid_o   = valid_q;
  assign product_o = prod_q;

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int WIDTH = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [WIDTH-1:0]     a_i,
  input logic [WIDTH-1:0]     b_i,
  input logic                 valid_o,
  input logic [2*WIDTH-1:0]   product_o
);
  localparam int PW = 2 * WIDTH;

  logic signed [PW-1:0] a_ext, b_ext;
  assign a_ext = {{WIDTH{a_i[WIDTH-1]}}, a_i};
  assign b_ext = {{WIDTH{b_i[WIDTH-1]}}, b_i};

  AST_PRODUCT_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) |-> product_o == PW'($past(a_ext) * $past(b_ext))); // R1

  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> $stable(product_o)); // R3

  AST_ZERO_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && (a_i == '0 || b_i == '0)) |-> product_o == '0); // R8

  AST_SIGN_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && a_i != '0 && b_i != '0)
      |-> product_o[PW-1] == $past(a_i[WIDTH-1] ^ b_i[WIDTH-1])); // R9

endmodule

bind booth_mul booth_mul_chk #(.WIDTH(WIDTH)) i_booth_mul_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .valid_o   (valid_o),
  .product_o (product_o)
);

// File: tb/test_booth_mul.sv
`timescale 1ns/1ps
module test_booth_mul;
  localparam int W  = 16;
  localparam int PW = 2 * W;

  logic          clk_i   = 1'b0;
  logic          rst_ni  = 1'b0;
  logic          valid_i = 1'b0;
  logic [W-1:0]  a_i     = '0;
  logic [W-1:0]  b_i     = '0;
  logic          valid_o;
  logic [PW-1:0] product_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  booth_mul #(.WIDTH(W)) i_booth_mul (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .valid_o   (valid_o),
    .product_o (product_o)
  );

  function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return PW'(sa * sb);
  endfunction

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one valid operation, result sampled at the next falling edge
  task automatic op(input string req, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk_i);
    valid_i = 1'b1; a_i = a; b_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(req, product_o, ref_mul(a, b));
    chk("R2 valid_o", PW'(valid_o), PW'(1));
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] held;
    logic [PW-1:0] exp_p;
    logic          exp_v;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk_i);
    chk("R4 reset valid_o", PW'(valid_o), '0);
    chk("R4 reset product_o", product_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R4 after release", product_o, '0);

    // R7 check value
    op("R7 25*-35", 16'd25, 16'hFFDD);
    chk("R7 constant", product_o, 32'hFFFFFC95);

    // R6 most negative operand
    op("R6 min*min", 16'h8000, 16'h8000);
    chk("R6 min*min const", product_o, 32'h40000000);
    op("R6 min*-1", 16'h8000, 16'hFFFF);
    chk("R6 min*-1 const", product_o, 32'h00008000);
    op("R6 -1*min", 16'hFFFF, 16'h8000);
    chk("R6 -1*min const", product_o, 32'h00008000);
    op("R6 min*max", 16'h8000, 16'h7FFF);

    // R8 zero operands
    op("R8 0*x", 16'h0000, 16'h9A3C);
    chk("R8 zero const", product_o, '0);
    op("R8 x*0", 16'h8001, 16'h0000);
    chk("R8 zero const", product_o, '0);

    // R5 every window value
    op("R5 b=all ones", 16'h1234, 16'hFFFF);
    op("R5 b=5555", 16'h7ABC, 16'h5555);
    op("R5 b=AAAA", 16'h7ABC, 16'hAAAA);
    op("R5 b=3333", 16'hC3A5, 16'h3333);
    op("R5 b=CCCC", 16'hC3A5, 16'hCCCC);
    op("R5 b=6666", 16'h8000, 16'h6666);
    op("R5 b=9999", 16'h8000, 16'h9999);
    op("R5 b=7FFF", 16'hFFFF, 16'h7FFF);

    // R9 sign bit on mixed signs
    op("R9 +*-", 16'd3, 16'hFFFD);
    chk("R9 sign", PW'(product_o[PW-1]), PW'(1));
    op("R9 -*-", 16'hFFFD, 16'hFFE3);
    chk("R9 sign", PW'(product_o[PW-1]), PW'(0));

    // R3 idle cycles with changing operands
    held = product_o;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      valid_i = 1'b0; a_i = W'($urandom); b_i = W'($urandom);
      @(negedge clk_i);
      chk("R3 hold product", product_o, held);
      chk("R2 idle valid_o", PW'(valid_o), '0);
    end

    // R1/R2/R3 random back-to-back stream
    exp_p = held;
    exp_v = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      logic [W-1:0] ra, rb;
      logic         rv;
      ra = W'($urandom);
      rb = W'($urandom);
      rv = ($urandom % 4) != 0;
      @(negedge clk_i);
      chk("R1 stream product", product_o, exp_p);
      chk("R2 stream valid", PW'(valid_o), PW'(exp_v));
      valid_i = rv; a_i = ra; b_i = rb;
      exp_v = rv;
      if (rv) exp_p = ref_mul(ra, rb);
    end
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R1 stream last", product_o, exp_p);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule